// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps a fast-page DRAM alive. After reset it waits out the power-up pause and then runs a burst of RAS-cycling wake-up cycles. Only after that burst does it raise a ready flag. It then keeps a refresh interval timer running, so that the full set of rows is refreshed inside the retention window. If the memory has seen no RAS activity from this block for longer than that window, it runs the wake-up burst again.

The block shares the RAS, CAS and address pins with an access controller. It raises `ref_req` and waits for `ref_gnt`. The access controller grants only after it has closed any open row, and keeps the grant until `ref_req` drops. While granted, the block drives the strobes through a fixed sequence of states:

- `ST_PWRUP`: power-up pause.
- `ST_IDLE`: nothing owed, or waiting for the old grant to drop.
- `ST_REQ`: request raised, grant awaited.
- `ST_SETUP`: CAS setup in CAS-before-RAS mode, or row address setup in RAS-only mode.
- `ST_RASLO`: RAS held low.
- `ST_PRECH`: RAS precharge.

The state moves through these transitions:

- `ST_PWRUP` goes to `ST_IDLE` when the pause ends.
- `ST_IDLE` goes to `ST_REQ` when work is owed and the grant is low.
- `ST_REQ` goes to `ST_SETUP` on grant.
- `ST_SETUP` goes to `ST_RASLO`, and `ST_RASLO` goes to `ST_PRECH`, each when its timer ends.
- `ST_PRECH` goes back to `ST_SETUP` while the burst has cycles left, and to `ST_IDLE` after the last one.

CAS-before-RAS refresh is the default mode. A parameter selects RAS-only refresh instead. In that mode CAS stays high and an internal row counter drives the address. Refresh ticks that arrive while the grant is withheld are counted up to a limit and issued back to back once the grant comes.

Top module: `dram_refresh_seq`

## Requirements
- R1: No request and no strobe activity occur during the first INIT_WAIT_CYC cycles after reset release. `ref_req` first rises between INIT_WAIT_CYC+1 and INIT_WAIT_CYC+3 cycles after release.
- R2: The first granted burst after power-up has exactly WAKE_CNT RAS cycles. `init_done` rises only after the last of them completes, and then stays high.
- R3: In CAS-before-RAS mode, all CAS lines (`cas_n` equal to all zeros) fall together T_CSR cycles before RAS falls. They stay low T_CHR cycles after RAS falls, for a CAS low pulse of T_CSR+T_CHR cycles. The CAS lines always carry the same value.
- R4: `we_n` is high at all times. In CAS-before-RAS mode `row_addr_oe` is low.
- R5: Every RAS low pulse lasts exactly T_RAS cycles. Successive RAS falls are at least 14 cycles apart (at least 110 ns at 8 ns per cycle).
- R6: RAS and CAS are driven low only while `ref_req` and `ref_gnt` are both high. `ref_req` stays high until the precharge of the last cycle of the burst ends. A new request waits until `ref_gnt` is low.
- R7: After `init_done`, one refresh is owed every REFI_CYC cycles. Each grant issues exactly the owed count, back to back.
- R8: The owed count saturates at MAX_PEND, and further ticks are dropped.
- R9: If LAPSE_CYC cycles pass with no RAS fall from this block, the next burst has at least WAKE_CNT cycles.
- R10: In RAS-only mode, `cas_n` stays all ones and `row_addr_oe` is high at every RAS fall. `row_addr` starts at 0 after reset, advances by one after each cycle, wraps to 0 after 2^ROW_W-1, and is stable while `row_addr_oe` is high.
- R11: During reset, `ras_n` is 1, `cas_n` is all ones, and `ref_req`, `strobe_own` and `init_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access controller, row closed |
| ref_req | output | 1 | Bus request for a refresh burst |
| strobe_own | output | 1 | High while this block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LINES | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for RAS-only refresh |
| row_addr_oe | output | 1 | Row address drive enable |
| init_done | output | 1 | Memory initialized and ready |

## Verification
The bench withholds the grant for whole numbers of refresh intervals plus half an interval, so the owed count at grant time is exact. Too many or too few cycles would show up if ticks were lost, double-counted, or not saturated at the limit. A long hold crosses the lapse window and expects a full wake-up burst; a design that ignored the lapse would issue only the saturated count. Edge monitors measure the CAS lead and hold around each RAS fall and the length of each RAS pulse, catching strobes reordered or cut short. A second instance in RAS-only mode runs past the row counter wrap, exposing an address that does not advance or does not wrap.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_REQ   = 3'd2,
        ST_SETUP = 3'd3,
        ST_RASLO = 3'd4,
        ST_PRECH = 3'd5
    } drs_state_e;

    function automatic int unsigned drs_max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
    parameter int unsigned INIT_WAIT_CYC = 62500,
    parameter int unsigned REFI_CYC      = 2000,
    parameter int unsigned LAPSE_CYC     = 2050000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    input  logic ras_fall,
    output logic pwr_ok,
    output logic refi_tick,
    output logic lapse_hit
);
    localparam int PW = $clog2(INIT_WAIT_CYC + 1);
    localparam int RW = $clog2(REFI_CYC + 1);
    localparam int LW = $clog2(LAPSE_CYC + 1);

    logic [PW-1:0] pwr_cnt;
    logic [RW-1:0] refi_cnt;
    logic [LW-1:0] lapse_cnt;

    assign pwr_ok    = (pwr_cnt == PW'(INIT_WAIT_CYC));
    assign refi_tick = init_done && (refi_cnt == RW'(REFI_CYC - 1));
    assign lapse_hit = init_done && !ras_fall && (lapse_cnt == LW'(LAPSE_CYC - 1));

    // power-up pause counter, stops at its limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_cnt <= '0;
        end else if (!pwr_ok) begin
            pwr_cnt <= pwr_cnt + 1'b1;
        end
    end

    // refresh interval, runs only once the memory is ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refi_cnt <= '0;
        end else if (!init_done || refi_tick) begin
            refi_cnt <= '0;
        end else begin
            refi_cnt <= refi_cnt + 1'b1;
        end
    end

    // cycles since the last RAS fall, saturating at the lapse limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lapse_cnt <= '0;
        end else if (ras_fall || !init_done) begin
            lapse_cnt <= '0;
        end else if (lapse_cnt != LW'(LAPSE_CYC)) begin
            lapse_cnt <= lapse_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drs_pend.sv
module drs_pend #(
    parameter int unsigned MAX_PEND = 8,
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    output logic [PEND_W-1:0] pend
);
    logic [PEND_W-1:0] pend_d;

    always_comb begin
        pend_d = clr ? '0 : pend;
        if (tick && (pend_d != PEND_W'(MAX_PEND))) begin
            pend_d = pend_d + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend_d;
        end
    end
endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (adv) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/drs_fsm.sv
module drs_fsm
    import drs_pkg::*;
#(
    parameter int unsigned T_CSR    = 2,
    parameter int unsigned T_CHR    = 2,
    parameter int unsigned T_RAS    = 8,
    parameter int unsigned T_RP     = 6,
    parameter int unsigned WAKE_CNT = 8,
    parameter int unsigned MAX_PEND = 8,
    parameter bit          RAS_ONLY = 1'b0,
    localparam int PEND_W  = $clog2(MAX_PEND + 1),
    localparam int BURST_W = $clog2(drs_max2(MAX_PEND, WAKE_CNT) + 1),
    localparam int TW      = $clog2(drs_max2(drs_max2(T_CSR, T_RAS), T_RP) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic [PEND_W-1:0] pend,
    input  logic              lapse_hit,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              strobe_own,
    output logic              ras_n,
    output logic              cas_all_n,
    output logic              addr_oe,
    output logic              init_done,
    output logic              pend_clr,
    output logic              ras_fall,
    output logic              row_adv
);
    drs_state_e         state_q, state_d;
    logic [TW-1:0]      tcnt_q;
    logic [BURST_W-1:0] burst_q;
    logic               wake_q;
    logic               done_q;
    logic               setup_end, raslo_end, prech_end, last_cyc;

    assign setup_end = (tcnt_q == TW'(T_CSR - 1));
    assign raslo_end = (tcnt_q == TW'(T_RAS - 1));
    assign prech_end = (tcnt_q == TW'(T_RP - 1));
    assign last_cyc  = (burst_q == BURST_W'(1));
    assign init_done = done_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (pwr_ok) state_d = ST_IDLE;
            ST_IDLE:  if (((pend != '0) || wake_q) && !ref_gnt) state_d = ST_REQ;
            ST_REQ:   if (ref_gnt) state_d = ST_SETUP;
            ST_SETUP: if (setup_end) state_d = ST_RASLO;
            ST_RASLO: if (raslo_end) state_d = ST_PRECH;
            ST_PRECH: if (prech_end) state_d = last_cyc ? ST_IDLE : ST_SETUP;
            default:  state_d = ST_PWRUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // phase timer, burst length, wake-up and ready flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            burst_q <= '0;
            wake_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            tcnt_q <= (state_d != state_q) ? '0 : tcnt_q + 1'b1;
            if (pend_clr) begin
                if (wake_q && (BURST_W'(pend) < BURST_W'(WAKE_CNT))) begin
                    burst_q <= BURST_W'(WAKE_CNT);
                end else begin
                    burst_q <= BURST_W'(pend);
                end
            end else if ((state_q == ST_PRECH) && prech_end) begin
                burst_q <= burst_q - 1'b1;
            end
            if (pend_clr) wake_q <= 1'b0;
            if (lapse_hit) wake_q <= 1'b1;
            if ((state_q == ST_PRECH) && prech_end && last_cyc) done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ref_req    = 1'b0;
        strobe_own = 1'b0;
        ras_n      = 1'b1;
        cas_all_n  = 1'b1;
        addr_oe    = 1'b0;
        unique case (state_q)
            ST_PWRUP, ST_IDLE: ;
            ST_REQ: ref_req = 1'b1;
            ST_SETUP: begin
                ref_req    = 1'b1;
                strobe_own = 1'b1;
                cas_all_n  = RAS_ONLY;
                addr_oe    = RAS_ONLY;
            end
            ST_RASLO: begin
                ref_req    = 1'b1;
                strobe_own = 1'b1;
                ras_n      = 1'b0;
                cas_all_n  = RAS_ONLY || (tcnt_q >= TW'(T_CHR));
                addr_oe    = RAS_ONLY;
            end
            ST_PRECH: begin
                ref_req    = 1'b1;
                strobe_own = 1'b1;
            end
            default: ;
        endcase
    end

    assign pend_clr = (state_q == ST_REQ) && ref_gnt;
    assign ras_fall = (state_q == ST_SETUP) && setup_end;
    assign row_adv  = RAS_ONLY && (state_q == ST_RASLO) && raslo_end;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int unsigned CAS_LINES     = 4,
    parameter int unsigned ROW_W         = 10,
    parameter bit          RAS_ONLY      = 1'b0,
    parameter int unsigned INIT_WAIT_CYC = 62500,
    parameter int unsigned REFI_CYC      = 2000,
    parameter int unsigned LAPSE_CYC     = 2050000,
    parameter int unsigned MAX_PEND      = 8,
    parameter int unsigned WAKE_CNT      = 8,
    parameter int unsigned T_CSR         = 2,
    parameter int unsigned T_CHR         = 2,
    parameter int unsigned T_RAS         = 8,
    parameter int unsigned T_RP          = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_gnt,
    output logic                 ref_req,
    output logic                 strobe_own,
    output logic                 ras_n,
    output logic [CAS_LINES-1:0] cas_n,
    output logic                 we_n,
    output logic [ROW_W-1:0]     row_addr,
    output logic                 row_addr_oe,
    output logic                 init_done
);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic              pwr_ok, refi_tick, lapse_hit;
    logic              pend_clr, ras_fall, row_adv;
    logic              cas_all_n, addr_oe;
    logic [PEND_W-1:0] pend;
    logic [ROW_W-1:0]  row_q;

    drs_timer #(
        .INIT_WAIT_CYC(INIT_WAIT_CYC),
        .REFI_CYC     (REFI_CYC),
        .LAPSE_CYC    (LAPSE_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_done(init_done),
        .ras_fall (ras_fall),
        .pwr_ok   (pwr_ok),
        .refi_tick(refi_tick),
        .lapse_hit(lapse_hit)
    );

    drs_pend #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (refi_tick),
        .clr  (pend_clr),
        .pend (pend)
    );

    drs_fsm #(
        .T_CSR   (T_CSR),
        .T_CHR   (T_CHR),
        .T_RAS   (T_RAS),
        .T_RP    (T_RP),
        .WAKE_CNT(WAKE_CNT),
        .MAX_PEND(MAX_PEND),
        .RAS_ONLY(RAS_ONLY)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .pend      (pend),
        .lapse_hit (lapse_hit),
        .ref_gnt   (ref_gnt),
        .ref_req   (ref_req),
        .strobe_own(strobe_own),
        .ras_n     (ras_n),
        .cas_all_n (cas_all_n),
        .addr_oe   (addr_oe),
        .init_done (init_done),
        .pend_clr  (pend_clr),
        .ras_fall  (ras_fall),
        .row_adv   (row_adv)
    );

    drs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (row_adv),
        .row  (row_q)
    );

    for (genvar i = 0; i < CAS_LINES; i++) begin : g_cas
        assign cas_n[i] = cas_all_n;
    end

    assign row_addr    = addr_oe ? row_q : '0;
    assign row_addr_oe = addr_oe;
    assign we_n        = 1'b1;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int unsigned CAS_LINES     = 4,
    parameter int unsigned ROW_W         = 10,
    parameter bit          RAS_ONLY      = 1'b0,
    parameter int unsigned INIT_WAIT_CYC = 62500,
    parameter int unsigned T_RAS         = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_gnt,
    input logic                 ref_req,
    input logic                 strobe_own,
    input logic                 ras_n,
    input logic [CAS_LINES-1:0] cas_n,
    input logic [ROW_W-1:0]     row_addr,
    input logic                 row_addr_oe,
    input logic                 init_done
);
    localparam int IW = $clog2(INIT_WAIT_CYC + 1);

    logic [IW-1:0] since_rst;
    logic [15:0]   ras_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != IW'(INIT_WAIT_CYC)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
        end else if (ras_n) begin
            ras_lo_cnt <= '0;
        end else if (ras_lo_cnt != 16'hFFFF) begin
            ras_lo_cnt <= ras_lo_cnt + 1'b1;
        end
    end

    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < IW'(INIT_WAIT_CYC)) |-> (!ref_req && ras_n)); // R1

    AST_INIT_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R2

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!RAS_ONLY && $fell(ras_n)) |-> ((cas_n == '0) && ($past(cas_n) == '0))); // R3

    AST_CAS_LINES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n == '0) || (cas_n == '1))); // R3

    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_cnt >= 16'(T_RAS))); // R5

    AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || (cas_n != '1)) |-> (ref_req && ref_gnt && strobe_own)); // R6

    AST_RO_ADDR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (RAS_ONLY && $fell(ras_n)) |-> row_addr_oe); // R10

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr_oe && $past(row_addr_oe)) |-> $stable(row_addr)); // R10
endmodule

bind dram_refresh_seq drs_checker #(
    .CAS_LINES    (CAS_LINES),
    .ROW_W        (ROW_W),
    .RAS_ONLY     (RAS_ONLY),
    .INIT_WAIT_CYC(INIT_WAIT_CYC),
    .T_RAS        (T_RAS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .strobe_own (strobe_own),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .row_addr   (row_addr),
    .row_addr_oe(row_addr_oe),
    .init_done  (init_done)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
    localparam int INIT_W = 50;
    localparam int REFI   = 200;
    localparam int LAPSE  = 2500;
    localparam int MAXP   = 4;
    localparam int WAKE   = 8;
    localparam int TCSR   = 2;
    localparam int TCHR   = 2;
    localparam int TRAS   = 8;
    localparam int RO_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // CAS-before-RAS instance
    logic       gnt = 1'b0;
    logic       req, own, ras_n, we_n, aoe, rdy;
    logic [3:0] cas_n;
    logic [9:0] addr;

    dram_refresh_seq #(
        .INIT_WAIT_CYC(INIT_W), .REFI_CYC(REFI), .LAPSE_CYC(LAPSE),
        .MAX_PEND(MAXP), .WAKE_CNT(WAKE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .strobe_own(own),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(addr),
        .row_addr_oe(aoe), .init_done(rdy)
    );

    // RAS-only instance
    logic            ro_gnt = 1'b0;
    logic            ro_req, ro_own, ro_ras_n, ro_we_n, ro_aoe, ro_rdy;
    logic [3:0]      ro_cas_n;
    logic [RO_W-1:0] ro_addr;

    dram_refresh_seq #(
        .ROW_W(RO_W), .RAS_ONLY(1'b1),
        .INIT_WAIT_CYC(INIT_W), .REFI_CYC(REFI), .LAPSE_CYC(LAPSE),
        .MAX_PEND(MAXP), .WAKE_CNT(WAKE)
    ) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ro_gnt), .ref_req(ro_req), .strobe_own(ro_own),
        .ras_n(ro_ras_n), .cas_n(ro_cas_n), .we_n(ro_we_n), .row_addr(ro_addr),
        .row_addr_oe(ro_aoe), .init_done(ro_rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int owed(input int j);
        return (j + 1 < MAXP) ? j + 1 : MAXP;
    endfunction

    function automatic int with_wake(input int p);
        return (p > WAKE) ? p : WAKE;
    endfunction

    // CAS-before-RAS edge monitor
    int  falls = 0;
    int  ras_lo_run = 0, cas_lo_run = 0, since_fall = 0;
    bit  seen_fall = 1'b0, prev_ras = 1'b1, prev_cas_hi = 1'b1, prev_rdy = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                chk(cas_n == 4'h0, "R3 cas low at ras fall", int'(cas_n), 0);
                chk(cas_lo_run >= TCSR, "R3 cas lead", cas_lo_run, TCSR);
                chk(gnt && req, "R6 grant at ras fall", int'(gnt), 1);
                chk(we_n && !aoe, "R4 we high addr off", int'({we_n, aoe}), 2);
                if (seen_fall) chk(since_fall >= 14, "R5 fall spacing", since_fall, 14);
                seen_fall = 1'b1;
                since_fall = 0;
                falls++;
            end
            if (!prev_ras && ras_n) chk(ras_lo_run == TRAS, "R5 ras low width", ras_lo_run, TRAS);
            if (!prev_cas_hi && (cas_n == 4'hF)) begin
                chk(!ras_n, "R3 cas held past ras fall", int'(ras_n), 0);
                chk(cas_lo_run == TCSR + TCHR, "R3 cas pulse", cas_lo_run, TCSR + TCHR);
            end
            if ((cas_n != 4'h0) && (cas_n != 4'hF)) chk(1'b0, "R3 cas lines split", int'(cas_n), 0);
            if (rdy && !prev_rdy) chk(falls == WAKE, "R2 ready after wake burst", falls, WAKE);
            if (!rdy && prev_rdy) chk(1'b0, "R2 ready dropped", 0, 1);
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            cas_lo_run = (cas_n == 4'h0) ? cas_lo_run + 1 : 0;
            since_fall++;
            prev_ras    = ras_n;
            prev_cas_hi = (cas_n == 4'hF);
            prev_rdy    = rdy;
        end
    end

    // RAS-only granter and monitor
    int ro_wait = 0, ro_falls = 0, ro_exp = 0, ro_lo_run = 0;
    bit ro_prev = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ro_req) begin
                if (ro_wait == 3) ro_gnt = 1'b1;
                else ro_wait++;
            end else begin
                ro_gnt  = 1'b0;
                ro_wait = 0;
            end
            if (ro_prev && !ro_ras_n) begin
                chk(ro_aoe, "R10 addr enable at fall", int'(ro_aoe), 1);
                chk(int'(ro_addr) == ro_exp, "R10 row address", int'(ro_addr), ro_exp);
                chk(ro_cas_n == 4'hF, "R10 cas high", int'(ro_cas_n), 15);
                ro_exp = (ro_exp + 1) % (1 << RO_W);
                ro_falls++;
            end
            if (!ro_prev && ro_ras_n) chk(ro_lo_run == TRAS, "R5 ro ras width", ro_lo_run, TRAS);
            ro_lo_run = ro_ras_n ? 0 : ro_lo_run + 1;
            ro_prev = ro_ras_n;
        end
    end

    task automatic serve(input int hold, input int exp, input string tag);
        int start;
        while (!req) @(negedge clk);
        repeat (hold) @(negedge clk);
        chk(ras_n && (cas_n == 4'hF) && !own, "R6 idle strobes before grant", int'(ras_n), 1);
        start = falls;
        gnt = 1'b1;
        @(negedge clk);
        while (req) @(negedge clk);
        gnt = 1'b0;
        chk(falls - start == exp, tag, falls - start, exp);
    endtask

    initial begin
        int c;
        int unsigned seed;
        seed = $urandom(32'h5EED1);
        repeat (3) @(negedge clk);
        chk(ras_n && (cas_n == 4'hF) && !req && !own && !rdy, "R11 reset state", int'(ras_n), 1);
        chk(ro_ras_n && (ro_cas_n == 4'hF) && !ro_req && !ro_rdy, "R11 ro reset state", int'(ro_ras_n), 1);
        rst_n = 1'b1;
        c = 0;
        while (!req && c < INIT_W + 20) begin
            @(negedge clk);
            c++;
            if (!req && !ras_n) chk(1'b0, "R1 strobe before request", c, 0);
        end
        chk(c >= INIT_W + 1 && c <= INIT_W + 3, "R1 first request delay", c, INIT_W + 2);
        chk(!rdy, "R2 not ready before wake burst", int'(rdy), 0);
        serve(2, WAKE, "R2 wake burst length");
        chk(rdy, "R2 ready after burst", int'(rdy), 1);
        // single owed refresh per interval
        for (int k = 0; k < 4; k++) begin
            serve(int'($urandom_range(0, 60)), 1, "R7 single refresh");
        end
        // owed refreshes build up while grant withheld
        for (int k = 0; k < 6; k++) begin
            int j;
            j = int'($urandom_range(0, 5));
            serve(j * REFI + REFI / 2, owed(j), "R7 backlog burst");
        end
        serve(9 * REFI + REFI / 2, owed(9), "R8 saturated backlog");
        serve(15 * REFI, with_wake(owed(15)), "R9 lapse rewake burst");
        serve(5, 1, "R7 after rewake");
        chk(rdy, "R2 ready held", int'(rdy), 1);
        chk(ro_rdy, "R2 ro ready", int'(ro_rdy), 1);
        chk(ro_falls > (1 << RO_W), "R10 row counter wrapped", ro_falls, (1 << RO_W) + 1);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule